// File: doc/BRIEF.md
# Dual-Mode Serial Configuration Slave

This block is the slave end of a three-wire link made of a select line, a serial clock and one bidirectional data line. Here the data line is split into a data input, a data output and an output-enable. The level of the select line picks the mode. While select is high, the link carries exactly one register transaction of two bytes. The first byte holds a direction flag and a 7-bit register index. The second byte is either stored into a 128-entry byte-wide register file or returned from it. While select is low, the same wires carry a stream of bytes. Every eight received bits come out as one byte on a parallel output with a one-cycle valid pulse. Bytes for the return direction are requested from a parallel input and shifted out on the data line.

All serial inputs are brought into the system clock domain through synchronisers. Edges of the serial clock are found by comparing successive synchronised samples. For this to work, the system clock must run at least four times as fast as the serial clock. Data output changes take up to about four system cycles after a serial falling edge, so the serial half-period must be longer than that. The register file is a simple dual-port array with a registered read, so it can map onto block RAM.

Top module: `cfg_link_slave`

## Requirements
- R1: After reset, `sdo_oe_o` and `rx_valid_o` are 0. If select is low, `tx_req_o` gives exactly one single-cycle pulse shortly after reset.
- R2: Every byte travels most significant bit first. The bit is sampled on the serial rising edge. A command byte with bit 7 = 1 is a write, and bits 6:0 are the register index. The following byte is stored at that index once the sixteenth falling edge is seen.
- R3: A command byte with bit 7 = 0 is a read. The output enable turns on after the eighth rising edge, and the register's value is placed on `sdo_o` MSB first for sampling on rising edges 9 to 16. A write transaction leaves the output enable off.
- R4: When select falls, the output enable is taken from `tx_en_i` within four system cycles. With `tx_en_i` low, the line is released.
- R5: If select falls before the sixteenth falling edge, no register is changed. This includes a drop after the sixteenth rising edge but before its falling edge.
- R6: Within one select-high window, clock edges after the sixteenth are ignored. A third byte is not written anywhere, and the index does not advance.
- R7: With select low, every eight received bits produce one single-cycle `rx_valid_o` pulse, with the assembled byte (MSB first) on `rx_byte_o`.
- R8: With select low, `tx_req_o` pulses once on entry to stream mode and once after every eighth received bit. The value on `tx_byte_i` in the cycle of that pulse is shifted out MSB first, with its first bit presented before the next rising edge.
- R9: In stream mode, `sdo_oe_o` follows `tx_en_i`.
- R10: Register transactions never produce an `rx_valid_o` pulse.
- R11: A read leaves the register contents unchanged, so two reads of one index return the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_i | input | 1 | Select line: high = register transaction, low = byte stream |
| sck_i | input | 1 | Serial clock from the master |
| sdi_i | input | 1 | Serial data from the master |
| sdo_o | output | 1 | Serial data towards the master |
| sdo_oe_o | output | 1 | Drive enable for the shared data line |
| tx_en_i | input | 1 | Stream mode: permits the slave to drive the data line |
| tx_byte_i | input | 8 | Stream mode: next byte to send, taken while `tx_req_o` is high |
| tx_req_o | output | 1 | Stream mode: single-cycle request for the next send byte |
| rx_byte_o | output | 8 | Stream mode: last received byte |
| rx_valid_o | output | 1 | Stream mode: single-cycle pulse, `rx_byte_o` is new |

## Verification
Each serial edge passes through two synchroniser stages and one edge register before the logic acts on it. Registered outputs then follow one cycle later. So `rx_valid_o`, `tx_req_o` and output-enable changes are due about four system cycles after the wire event, and a read bit reaches `sdo_o` within about five. The bench holds each serial clock phase for eight system cycles. It reads `sdo_o` on the last falling system edge before it raises the serial clock, and it checks enable and stream results only after a further full half-period. Every sample therefore lands well after the result is due and before the next wire event can change it.

// File: rtl/cfg_link_pkg.sv
`timescale 1ns/1ps
package cfg_link_pkg;
  // Progress of a register transaction inside one select-high window
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_CMD  = 2'd1,
    PH_DATA = 2'd2,
    PH_DONE = 2'd3
  } phase_t;

  // Value of the direction flag (top bit of the command byte) that means write
  localparam logic RW_WRITE = 1'b1;
endpackage

// File: rtl/cfg_link_sync.sv
`timescale 1ns/1ps
module cfg_link_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= din;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/cfg_link_regfile.sv
`timescale 1ns/1ps
module cfg_link_regfile #(
  parameter int DW = 8,
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= mem[rd_addr];
  end

  // A transaction reads after its command byte and writes after its data byte,
  // so both ports are never used in the same cycle
  p_port_exclusive_r2: assert property (@(posedge clk) disable iff (rst)
    !(we && rd_en));
endmodule

// File: rtl/cfg_link_slave.sv
`timescale 1ns/1ps
module cfg_link_slave #(
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sel_i,
  input  logic          sck_i,
  input  logic          sdi_i,
  output logic          sdo_o,
  output logic          sdo_oe_o,
  input  logic          tx_en_i,
  input  logic [DW-1:0] tx_byte_i,
  output logic          tx_req_o,
  output logic [DW-1:0] rx_byte_o,
  output logic          rx_valid_o
);
  import cfg_link_pkg::*;

  localparam int AW    = DW - 1;            // index bits after the direction flag
  localparam int FRAME = 2 * DW;            // bits in one register transaction
  localparam int CW    = $clog2(FRAME + 1);
  localparam int BW    = $clog2(DW + 1);

  // ---------------- synchronisers and edge detection ----------------
  logic [2:0] sync_out;
  logic       sel_s, sck_s, sdi_s;
  logic       sel_d, sck_d;

  cfg_link_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  ({sel_i, sck_i, sdi_i}),
    .dout (sync_out)
  );
  assign {sel_s, sck_s, sdi_s} = sync_out;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_d <= 1'b0;
      sck_d <= 1'b0;
    end else begin
      sel_d <= sel_s;
      sck_d <= sck_s;
    end
  end

  logic sel_rise, sck_rise, sck_fall;
  assign sel_rise = sel_s & ~sel_d;
  assign sck_rise = sck_s & ~sck_d;
  assign sck_fall = ~sck_s & sck_d;

  // ---------------- state ----------------
  phase_t        phase_q;
  logic [CW-1:0] cnt_q;
  logic [BW-1:0] fcnt_q;
  logic          samp_q;
  logic [DW-2:0] shift_q;
  logic          rw_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] txsh_q;
  logic          oe_q;
  logic          load_q;
  logic          primed_q;
  logic          tx_req_q;
  logic [DW-1:0] rx_byte_q;
  logic          rx_valid_q;
  logic          wr_seen_q;

  logic [DW-1:0] rx_full;
  assign rx_full = {shift_q, samp_q};

  // ---------------- register file access ----------------
  logic          cmd_done, data_done, rd_en, we;
  logic [DW-1:0] rd_data;

  assign cmd_done  = sck_fall && sel_s && (phase_q == PH_CMD)  && (cnt_q == CW'(DW));
  assign data_done = sck_fall && sel_s && (phase_q == PH_DATA) && (cnt_q == CW'(FRAME));
  assign rd_en     = cmd_done  && (rw_q != RW_WRITE);
  assign we        = data_done && (rw_q == RW_WRITE);

  cfg_link_regfile #(.DW(DW), .AW(AW)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .we      (we),
    .wr_addr (addr_q),
    .wr_data (rx_full),
    .rd_en   (rd_en),
    .rd_addr (rx_full[AW-1:0]),
    .rd_data (rd_data)
  );

  // ---------------- sequencing ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q    <= PH_IDLE;
      cnt_q      <= '0;
      fcnt_q     <= '0;
      samp_q     <= 1'b0;
      shift_q    <= '0;
      rw_q       <= 1'b0;
      addr_q     <= '0;
      txsh_q     <= '0;
      oe_q       <= 1'b0;
      load_q     <= 1'b0;
      primed_q   <= 1'b0;
      tx_req_q   <= 1'b0;
      rx_byte_q  <= '0;
      rx_valid_q <= 1'b0;
      wr_seen_q  <= 1'b0;
    end else begin
      tx_req_q   <= 1'b0;
      rx_valid_q <= 1'b0;
      load_q     <= rd_en;

      if (!sel_s) begin
        // -------- byte stream mode --------
        phase_q <= PH_IDLE;
        oe_q    <= tx_en_i;
        if (!primed_q) begin
          primed_q <= 1'b1;
          tx_req_q <= 1'b1;
          fcnt_q   <= '0;
        end
        if (tx_req_q) txsh_q <= tx_byte_i;
        if (sck_rise) begin
          samp_q <= sdi_s;
          fcnt_q <= fcnt_q + 1'b1;
        end else if (sck_fall) begin
          if (fcnt_q == BW'(DW)) begin
            rx_byte_q  <= rx_full;
            rx_valid_q <= 1'b1;
            fcnt_q     <= '0;
            tx_req_q   <= 1'b1;
          end else begin
            shift_q <= {shift_q[DW-3:0], samp_q};
            txsh_q  <= txsh_q << 1;
          end
        end
      end else begin
        // -------- register transaction mode --------
        primed_q <= 1'b0;
        if (sel_rise) begin
          phase_q   <= PH_CMD;
          cnt_q     <= '0;
          oe_q      <= 1'b0;
          txsh_q    <= '0;
          wr_seen_q <= 1'b0;
        end else if (phase_q == PH_CMD || phase_q == PH_DATA) begin
          if (sck_rise) begin
            samp_q <= sdi_s;
            cnt_q  <= cnt_q + 1'b1;
            if (phase_q == PH_CMD && cnt_q == CW'(DW - 1) && rw_q != RW_WRITE)
              oe_q <= 1'b1;
          end else if (sck_fall) begin
            shift_q <= {shift_q[DW-3:0], samp_q};
            if (phase_q == PH_CMD) begin
              if (cnt_q == CW'(1)) rw_q <= samp_q;
              if (cnt_q == CW'(DW)) begin
                addr_q  <= rx_full[AW-1:0];
                phase_q <= PH_DATA;
              end
            end else if (cnt_q == CW'(FRAME)) begin
              phase_q <= PH_DONE;
            end else begin
              txsh_q <= txsh_q << 1;
            end
          end
        end
        if (we) wr_seen_q <= 1'b1;
        if (load_q) txsh_q <= rd_data;
      end
    end
  end

  assign sdo_o      = txsh_q[DW-1];
  assign sdo_oe_o   = oe_q;
  assign tx_req_o   = tx_req_q;
  assign rx_byte_o  = rx_byte_q;
  assign rx_valid_o = rx_valid_q;

  // ---------------- assertions ----------------
  p_single_write_r6: assert property (@(posedge clk) disable iff (rst)
    we |-> !wr_seen_q);

  p_count_bound_r6: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(FRAME));

  p_oe_only_read_r3: assert property (@(posedge clk) disable iff (rst)
    (sel_s && (phase_q == PH_DATA || phase_q == PH_DONE) && sdo_oe_o) |-> (rw_q != RW_WRITE));

  p_rx_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    rx_valid_o |=> !rx_valid_o);

  p_req_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    tx_req_o |=> !tx_req_o);

  p_rx_stream_only_r10: assert property (@(posedge clk) disable iff (rst)
    rx_valid_o |-> !$past(sel_s));
endmodule

// File: tb/cfg_link_slave_bench.sv
`timescale 1ns/1ps
module cfg_link_slave_bench;
  localparam int H = 8;  // system cycles per serial clock phase

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sel = 1'b0, sck = 1'b0, sdi = 1'b0;
  logic       tx_en = 1'b0;
  logic [7:0] tx_byte = 8'h00;
  logic       sdo_o, sdo_oe_o, tx_req_o, rx_valid_o;
  logic [7:0] rx_byte_o;

  always #2.5 clk = ~clk;

  cfg_link_slave u_cfg_link_slave (
    .clk        (clk),
    .rst        (rst),
    .sel_i      (sel),
    .sck_i      (sck),
    .sdi_i      (sdi),
    .sdo_o      (sdo_o),
    .sdo_oe_o   (sdo_oe_o),
    .tx_en_i    (tx_en),
    .tx_byte_i  (tx_byte),
    .tx_req_o   (tx_req_o),
    .rx_byte_o  (rx_byte_o),
    .rx_valid_o (rx_valid_o)
  );

  int n_chk = 0, n_fail = 0;
  int rx_n = 0, req_n = 0;
  logic [7:0] rx_log [64];
  logic [7:0] model [128];
  bit done = 1'b0;

  // stream monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      if (rx_valid_o) begin
        rx_log[rx_n % 64] = rx_byte_o;
        rx_n++;
      end
      if (tx_req_o) req_n++;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_x(input logic b, output logic m);
    sdi = b;
    wait_cyc(H);
    m = sdo_o;
    sck = 1'b1;
    wait_cyc(H);
    sck = 1'b0;
  endtask

  task automatic cfg_xfer(input logic [23:0] frame, input int nb,
                          output logic [23:0] got, output logic oe_end);
    logic m;
    got = '0;
    sel = 1'b1;
    wait_cyc(H);
    for (int i = nb - 1; i >= 0; i--) begin
      bit_x(frame[i], m);
      got[i] = m;
    end
    wait_cyc(H);
    oe_end = sdo_oe_o;
    sel = 1'b0;
    wait_cyc(H);
  endtask

  task automatic cfg_write(input logic [6:0] a, input logic [7:0] d, output logic oe_end);
    logic [23:0] g;
    cfg_xfer({8'h00, 1'b1, a, d}, 16, g, oe_end);
  endtask

  task automatic cfg_read(input logic [6:0] a, output logic [7:0] d, output logic oe_end);
    logic [23:0] g;
    cfg_xfer({8'h00, 1'b0, a, 8'h00}, 16, g, oe_end);
    d = g[7:0];
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
    end
  end

  initial begin
    logic       oe;
    logic [7:0] d, d2;
    logic [6:0] a;
    logic [23:0] g;
    logic       m;
    void'($urandom(32'd7321));

    repeat (5) @(negedge clk);
    rst = 1'b0;
    wait_cyc(6);
    // R1: quiet outputs after reset, one entry request since select is low
    check("R1 oe after reset", sdo_oe_o, 0);
    check("R1 rx_valid after reset", rx_valid_o, 0);
    check("R1 entry request count", req_n, 1);

    // fill every register so the model is complete (R2)
    for (int i = 0; i < 128; i++) begin
      model[i] = 8'($urandom);
      cfg_write(7'(i), model[i], oe);
    end
    check("R3 write leaves oe off", oe, 0);

    // directed boundaries (R2, R3)
    cfg_write(7'd0, 8'h80, oe);   model[0]   = 8'h80;
    cfg_write(7'd127, 8'h01, oe); model[127] = 8'h01;
    cfg_read(7'd0, d, oe);
    check("R2 R3 read index 0", d, 8'h80);
    check("R3 oe on during read", oe, 1);
    wait_cyc(1);
    check("R4 oe released after select falls", sdo_oe_o, 0);
    cfg_read(7'd127, d, oe);
    check("R2 R3 read index 127", d, 8'h01);

    // random mix of writes and reads (R2, R3, R11)
    for (int k = 0; k < 40; k++) begin
      a = 7'($urandom);
      if ($urandom % 2 == 0) begin
        d = 8'($urandom);
        cfg_write(a, d, oe);
        model[a] = d;
      end else begin
        cfg_read(a, d, oe);
        check("R3 random read", d, model[a]);
        cfg_read(a, d2, oe);
        check("R11 repeat read unchanged", d2, model[a]);
      end
    end

    // R5: select drops after twelve bits
    a = 7'd42;
    cfg_xfer({8'h00, 1'b1, a, ~model[42]} >> 4, 12, g, oe);
    cfg_read(a, d, oe);
    check("R5 short frame not written", d, model[42]);

    // R5: select drops after the sixteenth rising edge, before its falling edge
    a = 7'd43;
    g = {8'h00, 1'b1, a, ~model[43]};
    sel = 1'b1;
    wait_cyc(H);
    for (int i = 15; i >= 1; i--) bit_x(g[i], m);
    sdi = g[0];
    wait_cyc(H);
    sck = 1'b1;
    wait_cyc(H);
    sel = 1'b0;
    wait_cyc(H);
    sck = 1'b0;
    wait_cyc(H);
    cfg_read(a, d, oe);
    check("R5 drop before last falling edge", d, model[43]);

    // R6: a third byte in the same window is ignored, no index advance
    a = 7'd60;
    d = 8'h3C;
    cfg_xfer({1'b1, a, d, 8'hC3}, 24, g, oe);
    model[60] = d;
    cfg_read(7'd60, d2, oe);
    check("R6 target holds second byte", d2, 8'h3C);
    cfg_read(7'd61, d2, oe);
    check("R6 next index unchanged", d2, model[61]);

    // R10: no stream output from any register transaction
    check("R10 no rx pulse during register traffic", rx_n, 0);

    // stream mode (R7, R8, R9)
    for (int b = 0; b < 4; b++) begin
      logic [7:0]  x, b1, b2;
      logic [15:0] mi;
      int req0, rx0;
      x  = 8'($urandom);
      b1 = 8'($urandom);
      b2 = 8'($urandom);
      tx_byte = x;
      tx_en = 1'b1;
      sel = 1'b1;          // empty window re-arms the entry request
      wait_cyc(H);
      sel = 1'b0;
      wait_cyc(H);
      check("R9 oe follows enable in stream mode", sdo_oe_o, 1);
      req0 = req_n;
      rx0  = rx_n;
      for (int i = 15; i >= 0; i--) begin
        bit_x((i >= 8) ? b1[i-8] : b2[i], m);
        mi[i] = m;
      end
      wait_cyc(H);
      check("R7 byte count", rx_n - rx0, 2);
      check("R7 first byte MSB first", rx_log[rx0 % 64], b1);
      check("R7 second byte", rx_log[(rx0 + 1) % 64], b2);
      check("R8 send bytes MSB first", mi, {x, x});
      check("R8 request per byte", req_n - req0, 2);
      tx_en = 1'b0;
      wait_cyc(4);
      check("R9 oe off when enable low", sdo_oe_o, 0);
    end

    // R4: select falls with enable high hands the line to stream mode
    tx_en = 1'b1;
    cfg_read(7'd5, d, oe);
    check("R4 oe taken from enable after select falls", sdo_oe_o, 1);
    check("R3 read index 5", d, model[5]);
    tx_en = 1'b0;
    wait_cyc(4);

    done = 1'b1;
    summary();
  end
endmodule